// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a parallel NOR-style flash array, modelled at the behavioural level. It watches bus write cycles for an optional two-write unlock prefix and a reset command. It accepts start pulses for a program, a sector erase and a bulk erase. It keeps the array's operating mode, which is one of: read, program busy, bulk erase busy, sector erase busy, error, or timed recovery. The array storage and the real erase algorithm are outside the block. Each program or erase simply stays busy for a fixed number of clock cycles, unless an external fail pulse ends it in the error state.

The reset command is honoured only in some modes. It cancels a sector erase and clears an error. It has no effect on a running program or bulk erase. A hardware reset input cancels any running operation. Every cancelled operation, and every recovery from an error through the reset command, passes through a recovery interval before the array is back in read mode. The length of that interval is derived from a clock-frequency parameter and a time in microseconds.

An eight-bit protection register holds one bit per sector. A request aimed at a protected sector is refused: the block goes straight to the error state and never becomes busy.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst` is high, and after it is released, the block is in read mode. `mode_o` uses the codes 0 read, 1 program, 2 bulk erase, 3 sector erase, 4 error and 5 recovery. In read mode `busy_o` is 0, `status_o` is 8'h80 and `prot_o` is 0. `status_o` bit 7 is the inverse of `busy_o`, bit 5 is the error flag, and all other bits are 0.
- R2: A `prog_start_i` pulse in read mode, aimed at an unprotected sector `sect_sel_i`, enters program mode on the next edge. The block stays busy for exactly BUSY_CYCLES cycles and then returns to read mode.
- R3: A `sect_start_i` pulse in read mode enters sector erase mode, and a `bulk_start_i` pulse enters bulk erase mode. Each stays busy for BUSY_CYCLES cycles. When several start pulses arrive together, program wins over sector erase, and sector erase wins over bulk erase.
- R4: A program or sector erase aimed at a sector whose `prot_o` bit is 1 goes to error mode with status bit 5 set and `busy_o` low. A bulk erase does the same when any protection bit is set. `prot_we_i` loads `prot_data_i` into the protection register on the next edge.
- R5: An `op_fail_i` pulse during a program, sector erase or bulk erase moves the block to error mode with status bit 5 set and `busy_o` low.
- R6: The reset command is a write of data F0h to any address. It may be given bare, or right after the unlock writes AAh to address 555h and then 55h to address AAAh. During a sector erase it aborts the erase and starts recovery. Recovery keeps `busy_o` high for RECOV_CYC = CLK_MHZ*RECOV_US cycles, and then the block is in read mode.
- R7: A reset command during a program or bulk erase is ignored, and that operation finishes on its normal schedule.
- R8: A reset command in error mode clears status bit 5 at once and starts recovery lasting RECOV_CYC cycles, after which the block is in read mode.
- R9: A write that breaks the unlock prefix sends the decoder back to idle. When that breaking write carries F0h it is not taken as a command. A bare F0h written on the following cycle is taken as a command.
- R10: `hw_rst_i` during a program or either erase starts recovery lasting RECOV_CYC cycles. In error mode it returns the block to read mode on the next edge with the flag cleared. During recovery it does not restart the count.
- R11: Start pulses are ignored in every mode other than read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_rst_i | input | 1 | Hardware reset request (abort input) |
| wr_en_i | input | 1 | Bus write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | 8 | Bus write data |
| prog_start_i | input | 1 | Program start pulse |
| sect_start_i | input | 1 | Sector erase start pulse |
| bulk_start_i | input | 1 | Bulk erase start pulse |
| sect_sel_i | input | $clog2(NSECT) | Target sector of program or sector erase |
| op_fail_i | input | 1 | Running operation failed |
| prot_we_i | input | 1 | Load the protection register |
| prot_data_i | input | NSECT | New protection bits |
| mode_o | output | 3 | Current mode code |
| busy_o | output | 1 | Operation or recovery in progress |
| status_o | output | 8 | Status byte: bit 7 ready, bit 5 error |
| prot_o | output | NSECT | Protection register contents |

## Verification
The bench builds the block with CLK_MHZ=2 and RECOV_US=2, which gives a four-cycle recovery, and with BUSY_CYCLES=6. The short busy window still leaves room for a full unlock-plus-reset sequence inside a running operation. It also makes the exact edge where each busy and recovery interval ends cheap to check, for every way of entering and leaving those intervals. The default values give a thousand-cycle recovery. That length is only bounded by a counter in the checker, and no exact-edge check covers it.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam logic [11:0] UNLK_ADDR_A = 12'h555;
    localparam logic [11:0] UNLK_ADDR_B = 12'hAAA;
    localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
    localparam logic [7:0]  UNLK_DATA_B = 8'h55;
    localparam logic [7:0]  RESET_CMD   = 8'hF0;

    typedef enum logic [2:0] {
        M_READ  = 3'd0,
        M_PROG  = 3'd1,
        M_BULK  = 3'd2,
        M_SECT  = 3'd3,
        M_ERROR = 3'd4,
        M_RECOV = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        D_IDLE = 2'd0,
        D_HALF = 2'd1,
        D_OPEN = 2'd2
    } dec_e;

    typedef struct packed {
        mode_e mode;
        logic  err;
    } seq_state_t;

    function automatic logic mode_busy(mode_e m);
        return (m == M_PROG) || (m == M_BULK) || (m == M_SECT) || (m == M_RECOV);
    endfunction

    function automatic logic [7:0] status_byte(logic busy, logic err);
        return {~busy, 1'b0, err, 5'b0_0000};
    endfunction

endpackage

// File: rtl/fcs_unlock_dec.sv
module fcs_unlock_dec
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              rst_cmd_o
);

    dec_e st_q, st_d;
    logic hit_a, hit_b, is_rst;

    assign hit_a  = (addr_i == ADDR_W'(UNLK_ADDR_A)) && (data_i == UNLK_DATA_A);
    assign hit_b  = (addr_i == ADDR_W'(UNLK_ADDR_B)) && (data_i == UNLK_DATA_B);
    assign is_rst = (data_i == RESET_CMD);

    always_comb begin
        st_d      = st_q;
        rst_cmd_o = 1'b0;
        if (wr_i) begin
            case (st_q)
                D_IDLE: begin
                    if (hit_a)       st_d = D_HALF;
                    else if (is_rst) rst_cmd_o = 1'b1;
                end
                D_HALF: st_d = hit_b ? D_OPEN : D_IDLE;
                D_OPEN: begin
                    st_d      = D_IDLE;
                    rst_cmd_o = is_rst;
                end
                default: st_d = D_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) st_q <= D_IDLE;
        else                st_q <= st_d;
    end

endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= val_i;
        else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/fcs_prot_reg.sv
module fcs_prot_reg #(
    parameter int NSECT = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we_i,
    input  logic [NSECT-1:0] data_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NSECT-1:0] prot_o,
    output logic             sel_hit_o,
    output logic             any_o
);

    for (genvar g = 0; g < NSECT; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)       prot_o[g] <= 1'b0;
            else if (we_i) prot_o[g] <= data_i[g];
        end
    end

    assign sel_hit_o = prot_o[sel_i];
    assign any_o     = |prot_o;

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int CLK_MHZ     = 40,
    parameter int RECOV_US    = 25,
    parameter int BUSY_CYCLES = 64,
    parameter int ADDR_W      = 12,
    parameter int NSECT       = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hw_rst_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        wr_addr_i,
    input  logic [7:0]               wr_data_i,
    input  logic                     prog_start_i,
    input  logic                     sect_start_i,
    input  logic                     bulk_start_i,
    input  logic [$clog2(NSECT)-1:0] sect_sel_i,
    input  logic                     op_fail_i,
    input  logic                     prot_we_i,
    input  logic [NSECT-1:0]         prot_data_i,
    output logic [2:0]               mode_o,
    output logic                     busy_o,
    output logic [7:0]               status_o,
    output logic [NSECT-1:0]         prot_o
);

    localparam int SEL_W     = $clog2(NSECT);
    localparam int RECOV_CYC = CLK_MHZ * RECOV_US;
    localparam int MAX_CYC   = (RECOV_CYC > BUSY_CYCLES) ? RECOV_CYC : BUSY_CYCLES;
    localparam int CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] BUSY_LD  = CNT_W'(BUSY_CYCLES - 1);
    localparam logic [CNT_W-1:0] RECOV_LD = CNT_W'(RECOV_CYC - 1);

    seq_state_t       cur_q, nxt;
    logic             rst_cmd;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic             sel_prot, any_prot;

    fcs_unlock_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (hw_rst_i),
        .wr_i      (wr_en_i),
        .addr_i    (wr_addr_i),
        .data_i    (wr_data_i),
        .rst_cmd_o (rst_cmd)
    );

    fcs_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .load_i (t_load),
        .val_i  (t_val),
        .done_o (t_done)
    );

    fcs_prot_reg #(.NSECT(NSECT), .SEL_W(SEL_W)) u_prot (
        .clk       (clk),
        .rst       (rst),
        .we_i      (prot_we_i),
        .data_i    (prot_data_i),
        .sel_i     (sect_sel_i),
        .prot_o    (prot_o),
        .sel_hit_o (sel_prot),
        .any_o     (any_prot)
    );

    // Next-state selection: hardware reset first, then commands, then completion.
    always_comb begin
        nxt    = cur_q;
        t_load = 1'b0;
        t_val  = BUSY_LD;
        case (cur_q.mode)
            M_READ: begin
                if (!hw_rst_i) begin
                    if (prog_start_i || sect_start_i) begin
                        if (sel_prot) begin
                            nxt.mode = M_ERROR;
                            nxt.err  = 1'b1;
                        end else begin
                            nxt.mode = prog_start_i ? M_PROG : M_SECT;
                            t_load   = 1'b1;
                        end
                    end else if (bulk_start_i) begin
                        if (any_prot) begin
                            nxt.mode = M_ERROR;
                            nxt.err  = 1'b1;
                        end else begin
                            nxt.mode = M_BULK;
                            t_load   = 1'b1;
                        end
                    end
                end
            end
            M_PROG, M_BULK, M_SECT: begin
                if (hw_rst_i || (rst_cmd && cur_q.mode == M_SECT)) begin
                    nxt.mode = M_RECOV;
                    t_load   = 1'b1;
                    t_val    = RECOV_LD;
                end else if (op_fail_i) begin
                    nxt.mode = M_ERROR;
                    nxt.err  = 1'b1;
                end else if (t_done) begin
                    nxt.mode = M_READ;
                end
            end
            M_ERROR: begin
                if (hw_rst_i) begin
                    nxt.mode = M_READ;
                    nxt.err  = 1'b0;
                end else if (rst_cmd) begin
                    nxt.mode = M_RECOV;
                    nxt.err  = 1'b0;
                    t_load   = 1'b1;
                    t_val    = RECOV_LD;
                end
            end
            M_RECOV: begin
                if (t_done) nxt.mode = M_READ;
            end
            default: begin
                nxt.mode = M_READ;
                nxt.err  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.mode <= M_READ;
            cur_q.err  <= 1'b0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign mode_o   = cur_q.mode;
    assign busy_o   = mode_busy(cur_q.mode);
    assign status_o = status_byte(busy_o, cur_q.err);

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int RECOV_CYC = 1000,
    parameter int NSECT     = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     hw_rst_i,
    input logic                     op_fail_i,
    input logic                     prog_start_i,
    input logic [$clog2(NSECT)-1:0] sect_sel_i,
    input logic [NSECT-1:0]         prot_o,
    input logic [2:0]               mode_o,
    input logic                     busy_o,
    input logic                     err_i
);

    logic [31:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (mode_o == 3'd5) run_q <= run_q + 32'd1;
        else                     run_q <= '0;
    end

    p_err_only_in_error_r5: assert property (@(posedge clk) disable iff (rst)
        err_i |-> (mode_o == 3'd4));

    p_hw_abort_r10: assert property (@(posedge clk) disable iff (rst)
        (hw_rst_i && (mode_o == 3'd1 || mode_o == 3'd2 || mode_o == 3'd3)) |=> (mode_o == 3'd5));

    p_prog_keeps_running_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd1 && !hw_rst_i && !op_fail_i) |=> (mode_o == 3'd1 || mode_o == 3'd0));

    p_prot_refused_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd0 && prog_start_i && prot_o[sect_sel_i] && !hw_rst_i)
            |=> (mode_o == 3'd4 && !busy_o && err_i));

    p_recov_exit_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd0));

    p_recov_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 3'd5) |-> (run_q < RECOV_CYC));

endmodule

bind flash_cmd_seq fcs_checker #(
    .RECOV_CYC (CLK_MHZ * RECOV_US),
    .NSECT     (NSECT)
) u_fcs_checker (
    .clk          (clk),
    .rst          (rst),
    .hw_rst_i     (hw_rst_i),
    .op_fail_i    (op_fail_i),
    .prog_start_i (prog_start_i),
    .sect_sel_i   (sect_sel_i),
    .prot_o       (prot_o),
    .mode_o       (mode_o),
    .busy_o       (busy_o),
    .err_i        (status_o[5])
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int BC = 6;

    typedef struct {
        logic        hw, wr;
        logic [11:0] a;
        logic [7:0]  d;
        logic        ps, ss, bs;
        logic [2:0]  sel;
        logic        fail, pwe;
        logic [7:0]  pd;
    } stim_t;

    typedef struct {
        logic [2:0] mode;
        logic       busy;
        logic       err;
        logic [7:0] prot;
        string      tag;
    } exp_t;

    logic clk = 1'b0, rst = 1'b1;
    logic hw_rst_i = 0, wr_en_i = 0, prog_start_i = 0, sect_start_i = 0, bulk_start_i = 0;
    logic op_fail_i = 0, prot_we_i = 0;
    logic [11:0] wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0, prot_data_i = '0;
    logic [2:0]  sect_sel_i = '0;
    logic [2:0]  mode_o;
    logic        busy_o;
    logic [7:0]  status_o, prot_o;

    exp_t q[$];
    exp_t it;
    logic [7:0] exp_prot = '0;
    int vectors = 0, miscompares = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(.CLK_MHZ(2), .RECOV_US(2), .BUSY_CYCLES(BC)) i_flash_cmd_seq (
        .clk(clk), .rst(rst), .hw_rst_i(hw_rst_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .prog_start_i(prog_start_i),
        .sect_start_i(sect_start_i), .bulk_start_i(bulk_start_i), .sect_sel_i(sect_sel_i),
        .op_fail_i(op_fail_i), .prot_we_i(prot_we_i), .prot_data_i(prot_data_i),
        .mode_o(mode_o), .busy_o(busy_o), .status_o(status_o), .prot_o(prot_o)
    );

    // Monitor: one expected item per clock edge, compared just after the edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            logic [7:0] es;
            it = q.pop_front();
            es = {~it.busy, 1'b0, it.err, 5'b0};
            vectors++;
            if (mode_o !== it.mode || busy_o !== it.busy || status_o !== es || prot_o !== it.prot) begin
                miscompares++;
                $display("FAIL %s: actual mode=%0d busy=%b status=%h prot=%h expected mode=%0d busy=%b status=%h prot=%h",
                         it.tag, mode_o, busy_o, status_o, prot_o, it.mode, it.busy, es, it.prot);
            end
        end
    end

    function automatic stim_t none();
        stim_t s;
        s.hw = 0; s.wr = 0; s.a = '0; s.d = '0; s.ps = 0; s.ss = 0; s.bs = 0;
        s.sel = '0; s.fail = 0; s.pwe = 0; s.pd = '0;
        return s;
    endfunction

    task automatic apply(stim_t s, logic [2:0] m, logic b, logic e, string tag);
        exp_t x;
        hw_rst_i = s.hw; wr_en_i = s.wr; wr_addr_i = s.a; wr_data_i = s.d;
        prog_start_i = s.ps; sect_start_i = s.ss; bulk_start_i = s.bs;
        sect_sel_i = s.sel; op_fail_i = s.fail; prot_we_i = s.pwe; prot_data_i = s.pd;
        if (s.pwe) exp_prot = s.pd;
        x.mode = m; x.busy = b; x.err = e; x.prot = exp_prot; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic idle(int n, logic [2:0] m, logic b, logic e, string tag);
        for (int i = 0; i < n; i++) apply(none(), m, b, e, tag);
    endtask

    task automatic bus(logic [11:0] a, logic [7:0] d, logic [2:0] m, logic b, logic e, string tag);
        stim_t s = none();
        s.wr = 1; s.a = a; s.d = d;
        apply(s, m, b, e, tag);
    endtask

    task automatic start(int kind, logic [2:0] sel, logic [2:0] m, logic b, logic e, string tag);
        stim_t s = none();
        s.sel = sel;
        if (kind == 0) s.ps = 1;
        if (kind == 1) s.ss = 1;
        if (kind == 2) s.bs = 1;
        apply(s, m, b, e, tag);
    endtask

    task automatic hw(logic [2:0] m, logic b, logic e, string tag);
        stim_t s = none();
        s.hw = 1;
        apply(s, m, b, e, tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        stim_t s;
        @(negedge clk);
        idle(1, 0, 0, 0, "R1 reset state");
        rst = 1'b0;
        idle(1, 0, 0, 0, "R1 after reset");

        // R2: program, exact length
        start(0, 3'd2, 1, 1, 0, "R2 program enter");
        idle(BC-1, 1, 1, 0, "R2 program busy");
        idle(1, 0, 0, 0, "R2 program done");

        // R3: sector and bulk erase
        start(1, 3'd5, 3, 1, 0, "R3 sector enter");
        idle(BC-1, 3, 1, 0, "R3 sector busy");
        idle(1, 0, 0, 0, "R3 sector done");
        start(2, 3'd0, 2, 1, 0, "R3 bulk enter");
        idle(BC-1, 2, 1, 0, "R3 bulk busy");
        idle(1, 0, 0, 0, "R3 bulk done");
        s = none(); s.ps = 1; s.ss = 1; s.bs = 1;
        apply(s, 1, 1, 0, "R3 priority program first");
        idle(BC-1, 1, 1, 0, "R3 priority busy");
        idle(1, 0, 0, 0, "R3 priority done");

        // R7: reset command during program and bulk ignored
        start(0, 3'd1, 1, 1, 0, "R7 program enter");
        bus(12'h000, 8'hF0, 1, 1, 0, "R7 bare reset ignored");
        bus(12'h555, 8'hAA, 1, 1, 0, "R7 unlock a");
        bus(12'hAAA, 8'h55, 1, 1, 0, "R7 unlock b");
        bus(12'h000, 8'hF0, 1, 1, 0, "R7 unlocked reset ignored");
        idle(1, 1, 1, 0, "R7 still busy");
        idle(1, 0, 0, 0, "R7 program on schedule");
        start(2, 3'd0, 2, 1, 0, "R7 bulk enter");
        bus(12'h555, 8'hAA, 2, 1, 0, "R7 bulk unlock a");
        bus(12'hAAA, 8'h55, 2, 1, 0, "R7 bulk unlock b");
        bus(12'h123, 8'hF0, 2, 1, 0, "R7 bulk reset ignored");
        idle(2, 2, 1, 0, "R7 bulk busy");
        idle(1, 0, 0, 0, "R7 bulk on schedule");

        // R11: starts ignored while busy
        start(0, 3'd0, 1, 1, 0, "R11 program enter");
        start(1, 3'd0, 1, 1, 0, "R11 sector start ignored");
        start(2, 3'd0, 1, 1, 0, "R11 bulk start ignored");
        idle(3, 1, 1, 0, "R11 busy");
        idle(1, 0, 0, 0, "R11 done on time");

        // R6: reset command aborts sector erase
        start(1, 3'd4, 3, 1, 0, "R6 sector enter");
        bus(12'h000, 8'hF0, 5, 1, 0, "R6 bare reset aborts");
        idle(3, 5, 1, 0, "R6 recovery");
        idle(1, 0, 0, 0, "R6 read after recovery");
        start(1, 3'd4, 3, 1, 0, "R6 sector enter 2");
        bus(12'h555, 8'hAA, 3, 1, 0, "R6 unlock a");
        bus(12'hAAA, 8'h55, 3, 1, 0, "R6 unlock b");
        bus(12'h7FF, 8'hF0, 5, 1, 0, "R6 unlocked reset aborts");
        idle(3, 5, 1, 0, "R6 recovery 2");
        idle(1, 0, 0, 0, "R6 read 2");

        // R9: broken prefix
        start(1, 3'd6, 3, 1, 0, "R9 sector enter");
        bus(12'h555, 8'hAA, 3, 1, 0, "R9 unlock a");
        bus(12'h555, 8'hF0, 3, 1, 0, "R9 breaking F0 not a command");
        bus(12'h000, 8'hF0, 5, 1, 0, "R9 decoder idle again");
        idle(3, 5, 1, 0, "R9 recovery");
        idle(1, 0, 0, 0, "R9 read");
        start(1, 3'd6, 3, 1, 0, "R9 sector enter 2");
        bus(12'h555, 8'hAA, 3, 1, 0, "R9 unlock a 2");
        bus(12'hAAB, 8'h55, 3, 1, 0, "R9 wrong address breaks");
        bus(12'h000, 8'hF0, 5, 1, 0, "R9 bare reset after break");
        idle(3, 5, 1, 0, "R9 recovery 2");
        idle(1, 0, 0, 0, "R9 read 2");

        // R4: protection
        s = none(); s.pwe = 1; s.pd = 8'h04;
        apply(s, 0, 0, 0, "R4 protection load");
        start(0, 3'd2, 4, 0, 1, "R4 protected program refused");
        idle(1, 4, 0, 1, "R4 error held");
        start(0, 3'd0, 4, 0, 1, "R11 start ignored in error");

        // R8: reset command clears error
        bus(12'h000, 8'hF0, 5, 1, 0, "R8 reset leaves error");
        idle(3, 5, 1, 0, "R8 recovery");
        idle(1, 0, 0, 0, "R8 read");

        start(2, 3'd0, 4, 0, 1, "R4 bulk refused with any protection");
        hw(0, 0, 0, "R10 hw reset in error");
        start(1, 3'd2, 4, 0, 1, "R4 protected sector erase refused");
        hw(0, 0, 0, "R10 hw reset in error 2");
        start(1, 3'd3, 3, 1, 0, "R4 unprotected sector runs");
        idle(BC-1, 3, 1, 0, "R4 sector busy");
        idle(1, 0, 0, 0, "R4 sector done");

        // R5: failure
        start(0, 3'd0, 1, 1, 0, "R5 program enter");
        s = none(); s.fail = 1;
        apply(s, 4, 0, 1, "R5 program fail");
        hw(0, 0, 0, "R5 cleared");
        s = none(); s.pwe = 1; s.pd = 8'h00;
        apply(s, 0, 0, 0, "R4 protection cleared");
        start(2, 3'd0, 2, 1, 0, "R5 bulk enter");
        idle(2, 2, 1, 0, "R5 bulk busy");
        s = none(); s.fail = 1;
        apply(s, 4, 0, 1, "R5 bulk fail");
        bus(12'h000, 8'hF0, 5, 1, 0, "R8 reset after bulk fail");
        idle(3, 5, 1, 0, "R8 recovery 2");
        idle(1, 0, 0, 0, "R8 read 2");

        // R10: hardware reset
        start(0, 3'd7, 1, 1, 0, "R10 program enter");
        hw(5, 1, 0, "R10 program aborted");
        idle(3, 5, 1, 0, "R10 recovery");
        idle(1, 0, 0, 0, "R10 read");
        start(2, 3'd0, 2, 1, 0, "R10 bulk enter");
        hw(5, 1, 0, "R10 bulk aborted");
        idle(3, 5, 1, 0, "R10 recovery bulk");
        idle(1, 0, 0, 0, "R10 read bulk");
        start(1, 3'd1, 3, 1, 0, "R10 sector enter");
        bus(12'h000, 8'hF0, 5, 1, 0, "R10 sector reset command");
        hw(5, 1, 0, "R10 hw reset in recovery no restart");
        idle(2, 5, 1, 0, "R10 recovery continues");
        idle(1, 0, 0, 0, "R10 recovery not extended");
        hw(0, 0, 0, "R10 hw reset in read");

        idle(2, 0, 0, 0, "R1 final idle");
        done = 1;
        finish_run();
    end

endmodule